// File: doc/BRIEF.md
# Handshaked Keyboard Input Port

This block is an 8-bit input port placed on a microcontroller's demultiplexed bus, facing a keyboard-like source. The CPU sees two byte locations: a status location and a data location. The port decodes them from a 16-bit address using only the upper five address bits and bit 0. Address bits 10 through 1 are ignored, so each location repeats across a 2 KB window.

The peripheral places a byte on its data lines and raises its strobe. The port passes the strobe through a two-stage synchronizer. On the synchronized rising edge it captures the byte and sets a ready flag. The CPU polls the flag on bit 7 of the status location, then reads the data location.

A read of the data location while the flag is set clears the flag and raises the acknowledge line. Acknowledge stays high until the peripheral drops its strobe. This completes a four-phase interlocked exchange. A new strobe edge is accepted only when the port is idle.

Top module: `kbd_hs_port`

## Requirements
- R1: An address whose bits 15..11 equal 10100 selects the port. Within that window, bit 0 low selects the status location and bit 0 high selects the data location. Bits 10..1 have no effect. Any address outside 0xA000–0xA7FF selects nothing.
- R2: `rd_valid` is high, and `rd_data` is nonzero only when `rd_valid` is high, only while `bus_e` is 1, `bus_rd` is 1 (1 = read) and a location is selected.
- R3: A status read returns the ready flag on bit 7 and zeros on bits 6..0.
- R4: A data read returns all eight bits of the data register.
- R5: A rising edge of `kb_strobe` is acted on at the third clock edge after it. At that edge the port loads `kb_data` into the data register and sets the ready flag, provided the port is idle.
- R6: A data read while the ready flag is set clears the flag and raises `kb_ack` at the clock edge that ends the read cycle.
- R7: `kb_ack` stays high while the strobe is high. It falls at the third clock edge after `kb_strobe` goes low.
- R8: A strobe rising edge that arrives while the ready flag is set or `kb_ack` is high changes neither the data register nor the flag.
- R9: Reset (asynchronous assert, synchronous release) clears the data register, the ready flag and `kb_ack`.
- R10: While the flag stays set, the data register holds its value. A data read with the flag clear returns the held byte and does not raise `kb_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address bus |
| bus_e | input | 1 | Bus phase clock, high during the data phase |
| bus_rd | input | 1 | Read/write, 1 = read |
| rd_data | output | 8 | Read data returned to the CPU |
| rd_valid | output | 1 | High while a port read strobe is active |
| kb_data | input | 8 | Peripheral data lines |
| kb_strobe | input | 1 | Peripheral data-valid strobe |
| kb_ack | output | 1 | Acknowledge back to the peripheral |

## Verification
The checks assume the peripheral follows the interlocked protocol. The data lines must be stable from before the strobe rises until the strobe's synchronized rising edge has been taken. The strobe is raised again only after acknowledge has dropped, or else deliberately while the flag is still set. The stimulus changes `kb_data` and `kb_strobe` only one nanosecond after a clock edge, and it keeps each strobe level for at least two clocks. Bus reads hold address, `bus_e` and `bus_rd` steady for one whole clock cycle. No status read and data read are ever requested together.

// File: rtl/kbdport_pkg.sv
package kbdport_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_FULL = 2'd1,
    PS_ACK  = 2'd2
  } port_state_e;

  typedef struct packed {
    logic stat_rd;
    logic data_rd;
  } rd_strobe_t;

endpackage

// File: rtl/kbdport_rst_sync.sv
module kbdport_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/kbdport_sync.sv
module kbdport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/kbdport_decode.sv
module kbdport_decode
  import kbdport_pkg::*;
#(
  parameter int                 MATCH_W   = 5,
  parameter logic [MATCH_W-1:0] MATCH_VAL = 5'b10100
) (
  input  logic               bus_e,
  input  logic               bus_rd,
  input  logic [MATCH_W-1:0] addr_hi,
  input  logic               addr_lsb,
  output rd_strobe_t         strobes
);

  logic window_hit;
  logic read_phase;

  always_comb begin
    window_hit      = (addr_hi == MATCH_VAL);
    read_phase      = bus_e & bus_rd;
    strobes.stat_rd = read_phase & window_hit & ~addr_lsb;
    strobes.data_rd = read_phase & window_hit & addr_lsb;
  end

endmodule

// File: rtl/kbdport_core.sv
module kbdport_core
  import kbdport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_sync,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              data_rd,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_q,
  output logic              ack_q
);

  port_state_e state_q, state_d;
  logic        prev_q;
  logic        stb_rise;
  logic        flag_d;
  logic        ack_d;
  logic        load_en;

  assign stb_rise = stb_sync & ~prev_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    ack_d   = ack_q;
    load_en = 1'b0;
    case (state_q)
      PS_IDLE: begin
        if (stb_rise) begin
          load_en = 1'b1;
          flag_d  = 1'b1;
          state_d = PS_FULL;
        end
      end
      PS_FULL: begin
        // a data read clears the flag; fresh strobe edges are dropped here
        if (data_rd) begin
          flag_d  = 1'b0;
          ack_d   = 1'b1;
          state_d = PS_ACK;
        end
      end
      PS_ACK: begin
        if (!stb_sync) begin
          ack_d   = 1'b0;
          state_d = PS_IDLE;
        end
      end
      default: begin
        flag_d  = 1'b0;
        ack_d   = 1'b0;
        state_d = PS_IDLE;
      end
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      flag_q  <= 1'b0;
      ack_q   <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      ack_q   <= ack_d;
      prev_q  <= stb_sync;
    end
  end

  // data register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (load_en) begin
      data_q <= pin_data;
    end
  end

endmodule

// File: rtl/kbd_hs_port.sv
module kbd_hs_port
  import kbdport_pkg::*;
#(
  parameter int                 ADDR_W    = 16,
  parameter int                 DATA_W    = 8,
  parameter int                 MATCH_W   = 5,
  parameter logic [MATCH_W-1:0] MATCH_VAL = 5'b10100,
  parameter int                 SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_e,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [DATA_W-1:0] kb_data,
  input  logic              kb_strobe,
  output logic              kb_ack
);

  localparam int STAT_BIT = DATA_W - 1;
  localparam int HI_LSB   = ADDR_W - MATCH_W;

  logic              rst_sync_n;
  logic              stb_sync;
  rd_strobe_t        strobes;
  logic [DATA_W-1:0] data_q;
  logic              status_flag;
  logic              dont_care_unused;

  assign dont_care_unused = ^bus_addr[HI_LSB-1:1];

  kbdport_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  kbdport_sync #(.STAGES(SYNC_STG)) u_stb_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (kb_strobe),
    .dout (stb_sync)
  );

  kbdport_decode #(.MATCH_W(MATCH_W), .MATCH_VAL(MATCH_VAL)) u_dec (
    .bus_e   (bus_e),
    .bus_rd  (bus_rd),
    .addr_hi (bus_addr[ADDR_W-1:HI_LSB]),
    .addr_lsb(bus_addr[0]),
    .strobes (strobes)
  );

  kbdport_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stb_sync(stb_sync),
    .pin_data(kb_data),
    .data_rd (strobes.data_rd),
    .data_q  (data_q),
    .flag_q  (status_flag),
    .ack_q   (kb_ack)
  );

  // read return mux
  always_comb begin
    rd_valid = strobes.stat_rd | strobes.data_rd;
    rd_data  = '0;
    if (strobes.data_rd) begin
      rd_data = data_q;
    end else if (strobes.stat_rd) begin
      rd_data[STAT_BIT] = status_flag;
    end
  end

endmodule

// File: rtl/kbd_hs_port_chk.sv
module kbd_hs_port_chk #(
  parameter int                 ADDR_W    = 16,
  parameter int                 DATA_W    = 8,
  parameter int                 MATCH_W   = 5,
  parameter logic [MATCH_W-1:0] MATCH_VAL = 5'b10100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_e,
  input logic              bus_rd,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              kb_strobe,
  input logic              kb_ack,
  input logic              flag,
  input logic [DATA_W-1:0] data_q
);

  logic in_window;
  logic data_read_seen;

  assign in_window      = (bus_addr[ADDR_W-1 -: MATCH_W] == MATCH_VAL);
  assign data_read_seen = bus_e && bus_rd && in_window && bus_addr[0];

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (bus_e && bus_rd)); // R2

  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> in_window); // R1

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !bus_addr[0]) |-> (rd_data[DATA_W-2:0] == '0)); // R3

  AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kb_ack) |-> ($past(data_read_seen) && $past(flag))); // R6

  AST_ACK_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(kb_ack && flag)); // R6

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kb_ack) |-> !$past(kb_strobe, 2)); // R7

  AST_NO_SET_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> !$past(kb_ack)); // R8

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && $past(flag)) |-> $stable(data_q)); // R10

endmodule

bind kbd_hs_port kbd_hs_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_W(MATCH_W), .MATCH_VAL(MATCH_VAL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_addr (bus_addr),
  .bus_e    (bus_e),
  .bus_rd   (bus_rd),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .kb_strobe(kb_strobe),
  .kb_ack   (kb_ack),
  .flag     (status_flag),
  .data_q   (data_q)
);

// File: tb/kbd_hs_port_test.sv
`timescale 1ns/1ps
module kbd_hs_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        bus_e;
  logic        bus_rd;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [7:0]  kb_data;
  logic        kb_strobe;
  logic        kb_ack;

  typedef struct {
    logic       vld;
    logic [7:0] dat;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #5 clk = ~clk;

  kbd_hs_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_e(bus_e),
    .bus_rd(bus_rd), .rd_data(rd_data), .rd_valid(rd_valid),
    .kb_data(kb_data), .kb_strobe(kb_strobe), .kb_ack(kb_ack)
  );

  // driver: one bus cycle, expected result pushed to the scoreboard
  task automatic rd(input logic [15:0] a, input logic ev, input logic [7:0] ed,
                    input string tag, input logic e = 1'b1, input logic r = 1'b1);
    exp_t it;
    bus_addr = a;
    bus_e    = e;
    bus_rd   = r;
    it.vld = ev;
    it.dat = ed;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    #1;
    bus_e  = 1'b0;
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic ack_is(input logic ex, input string tag);
    n_tests++;
    if (kb_ack !== ex) begin
      n_fail++;
      $display("FAIL %s: kb_ack actual %b expected %b", tag, kb_ack, ex);
    end
  endtask

  // monitor: compare bus results mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #4;
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_tests++;
        if (rd_valid !== it.vld || rd_data !== it.dat) begin
          n_fail++;
          $display("FAIL %s: actual valid=%b data=%h expected valid=%b data=%h",
                   it.tag, rd_valid, rd_data, it.vld, it.dat);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_e = 1'b0; bus_rd = 1'b0;
    kb_data = '0; kb_strobe = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    ack_is(1'b0, "R9 ack in reset");
    rst_n = 1'b1;
    tick(3);
    rd(16'hA000, 1'b1, 8'h00, "R9 status after reset");
    rd(16'hA001, 1'b1, 8'h00, "R9 data after reset");

    // R2 gating
    rd(16'hA000, 1'b0, 8'h00, "R2 E low", 1'b0, 1'b1);
    rd(16'hA001, 1'b0, 8'h00, "R2 write cycle", 1'b1, 1'b0);

    // R1 decode
    rd(16'h2000, 1'b0, 8'h00, "R1 A15 low");
    rd(16'hA800, 1'b0, 8'h00, "R1 A11 high");
    rd(16'hB000, 1'b0, 8'h00, "R1 A12 high");
    rd(16'hA7FE, 1'b1, 8'h00, "R1 status alias");

    // R5 capture timing, R3 status format
    kb_data = 8'h5A; kb_strobe = 1'b1;
    tick(2);
    rd(16'hA000, 1'b1, 8'h00, "R5 not yet captured");
    rd(16'hA000, 1'b1, 8'h80, "R5 R3 flag on bit 7");
    rd(16'hA3F0, 1'b1, 8'h80, "R1 status alias set");

    // R4 data read, R6 clear and ack
    rd(16'hA001, 1'b1, 8'h5A, "R4 data byte");
    ack_is(1'b1, "R6 ack raised");
    rd(16'hA000, 1'b1, 8'h00, "R6 flag cleared");

    // R7 ack release
    tick(3);
    ack_is(1'b1, "R7 ack held");
    kb_strobe = 1'b0;
    tick(2);
    ack_is(1'b1, "R7 ack still high at edge 2");
    tick(1);
    ack_is(1'b0, "R7 ack dropped at edge 3");

    // R10 idle read
    rd(16'hA7FF, 1'b1, 8'h5A, "R10 R1 idle data read");
    ack_is(1'b0, "R10 no ack when idle");
    rd(16'hA000, 1'b1, 8'h00, "R10 flag stays clear");

    // R8 ignored edge while full
    kb_data = 8'hC3; kb_strobe = 1'b1;
    tick(4);
    rd(16'hA000, 1'b1, 8'h80, "R5 second byte");
    kb_strobe = 1'b0;
    tick(3);
    kb_data = 8'h11; kb_strobe = 1'b1;
    tick(4);
    rd(16'hA000, 1'b1, 8'h80, "R8 flag kept");
    rd(16'hA001, 1'b1, 8'hC3, "R8 R10 data kept");
    ack_is(1'b1, "R6 ack second");
    kb_strobe = 1'b0;
    tick(4);
    ack_is(1'b0, "R7 ack second drop");

    // another pattern
    kb_data = 8'hA5; kb_strobe = 1'b1;
    tick(4);
    rd(16'hA001, 1'b1, 8'hA5, "R4 pattern A5");
    kb_strobe = 1'b0;
    tick(4);

    // R9 reset mid-transfer
    kb_data = 8'hFF; kb_strobe = 1'b1;
    tick(4);
    rd(16'hA000, 1'b1, 8'h80, "R5 before reset");
    rst_n = 1'b0; kb_strobe = 1'b0;
    tick(1);
    ack_is(1'b0, "R9 ack cleared");
    rst_n = 1'b1;
    tick(3);
    rd(16'hA000, 1'b1, 8'h00, "R9 flag cleared");
    rd(16'hA001, 1'b1, 8'h00, "R9 data cleared");

    tick(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule